// File: doc/BRIEF.md
# DMA Page Translation Unit

This block stands between DMA masters and system memory. Every DMA request brings a 24-bit device address, the number of address lines the device actually drives, a read/write flag and a transfer length in bytes. The unit folds narrow device addresses into the top of the 24-bit input space. It looks up one of 2048 page descriptors (8 KB pages) and checks the request against that descriptor. It then answers with either a 32-bit physical address plus an uncacheable attribute, or a fault with a cause code.

The CPU fills the descriptor table through a simple indexed port that writes and reads whole 32-bit descriptors. Descriptor layout:
- bits 31..13: physical page number
- bits 12..7: reserved
- bit 6: no-cache
- bit 5: block-only
- bit 4: modified
- bit 3: used
- bit 2: write-protect
- bits 1..0: type

The unit keeps the used and modified bits current for every successful access. Requests flow through a two-stage pipeline under valid/ready handshakes on both the request and the response side.

Top module: `dpx_xlate_top`

## Requirements
- R1: After reset every descriptor reads back as 0 on `cpu_rdata`, and any DMA request then faults with cause 1.
- R2: A CPU write stores the descriptor with bits 12..7 cleared. `cpu_rdata` presents the entry selected by `cpu_idx` one clock after that index is applied.
- R3: On success (`rsp_fault`=0, `rsp_cause`=0) `rsp_paddr` carries descriptor bits 31..13 above the folded request offset bits 12..0, and `rsp_nocache` equals descriptor bit 6.
- R4: When `req_dev_bits` is below 24, every request address bit at or above that count is forced to 1 before lookup. A value of 24 or more leaves the address unchanged. Descriptor index = folded address bits 23..13.
- R5: Descriptor type 00 faults with cause 1 and types 10 and 11 fault with cause 2. The type checks take priority over every other check.
- R6: A write to a page whose bit 2 is set faults with cause 3. A read of the same page succeeds.
- R7: When bit 5 is set, a length that is not a multiple of 16 faults with cause 4. Write protection (cause 3) takes priority over this check.
- R8: A successful access sets bit 3 of its descriptor, and a successful write also sets bit 4. A faulting access leaves the stored descriptor unchanged.
- R9: A response becomes valid two clocks after its request is accepted. It holds steady while `rsp_ready` is low, and `req_ready` drops while both stages are occupied and the response is blocked.
- R10: A CPU write to the index a request looks up, in the same cycle the request is accepted, is seen by that request.
- R11: A fault response drives `rsp_paddr` to 0 and `rsp_nocache` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | Descriptor write strobe |
| cpu_idx | input | 11 | Descriptor index for CPU write and read |
| cpu_wdata | input | 32 | Descriptor value to write |
| cpu_rdata | output | 32 | Descriptor at the index applied one clock earlier |
| req_valid | input | 1 | DMA request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | 24 | Device address |
| req_dev_bits | input | 5 | Number of address lines the device drives |
| req_write | input | 1 | 1 = write transfer, 0 = read |
| req_len | input | 16 | Transfer length in bytes |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed this cycle when high with rsp_valid |
| rsp_fault | output | 1 | Request refused |
| rsp_cause | output | 3 | 0 ok, 1 unused entry, 2 malformed type, 3 write-protected, 4 block size |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_nocache | output | 1 | Page must not be cached |

## Verification
The bench builds the unit with its default parameters: a 24-bit input space, 8 KB pages, 16-bit lengths and 16-byte blocks. This gives the full 2048-entry table, so the topmost index and the fold of a 16-bit or a zero-width device are reachable. The 4-bit low length field lets the bench hit lengths on and off the block boundary. Directed runs cover the fault priority between write protection and block size, the same-cycle write bypass, the used/modified bookkeeping read back over the CPU port, and a stalled response that fills both pipeline stages.

// File: rtl/dpx_pkg.sv
package dpx_pkg;

  localparam int DESC_W      = 32;
  localparam int BIT_WPROT   = 2;
  localparam int BIT_USED    = 3;
  localparam int BIT_MOD     = 4;
  localparam int BIT_BLOCK   = 5;
  localparam int BIT_NOCACHE = 6;
  localparam int FLAG_TOP    = 6;

  typedef enum logic [2:0] {
    XC_NONE    = 3'd0,
    XC_UNUSED  = 3'd1,
    XC_BADTYPE = 3'd2,
    XC_WPROT   = 3'd3,
    XC_BLOCK   = 3'd4
  } xcause_e;

  typedef struct packed {
    logic              fault;
    xcause_e           cause;
    logic [DESC_W-1:0] paddr;
    logic              nocache;
    logic              set_used;
    logic              set_mod;
  } verdict_t;

  // Mask that clears the reserved gap between the flags and the page field.
  function automatic logic [DESC_W-1:0] keep_mask(input int page_bits);
    logic [DESC_W-1:0] m;
    m = '1;
    for (int b = FLAG_TOP + 1; b < page_bits; b++) m[b] = 1'b0;
    return m;
  endfunction

endpackage

// File: rtl/dpx_desc_store.sv
module dpx_desc_store
  import dpx_pkg::*;
#(
  parameter int IDX_W     = 11,
  parameter int PAGE_BITS = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [IDX_W-1:0]  cpu_idx,
  input  logic [DESC_W-1:0] cpu_wdata,
  output logic [DESC_W-1:0] cpu_rdata,
  input  logic              lk_en,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [DESC_W-1:0] lk_desc,
  input  logic              wb_en,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic [DESC_W-1:0] wb_mask
);

  localparam int NENT = 1 << IDX_W;
  localparam logic [DESC_W-1:0] KEEP = keep_mask(PAGE_BITS);

  logic [DESC_W-1:0] mem [NENT];
  logic [NENT-1:0]   filled;

  logic [DESC_W-1:0] wclean;
  logic              wb_blocked;
  logic              wb_do;
  logic [DESC_W-1:0] lk_stored;
  logic [DESC_W-1:0] cpu_stored;

  assign wclean     = cpu_wdata & KEEP;
  assign wb_blocked = cpu_we && (cpu_idx == wb_idx);
  assign wb_do      = wb_en && !wb_blocked;
  assign lk_stored  = filled[lk_idx]  ? mem[lk_idx]  : '0;
  assign cpu_stored = filled[cpu_idx] ? mem[cpu_idx] : '0;

  // Array body carries no reset; the filled vector masks stale content.
  always_ff @(posedge clk) begin
    if (cpu_we) mem[cpu_idx] <= wclean;
    if (wb_do)  mem[wb_idx]  <= mem[wb_idx] | wb_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) filled <= '0;
    else if (cpu_we) filled[cpu_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cpu_rdata <= '0;
    else        cpu_rdata <= cpu_stored;
  end

  // Lookup read with bypass: same-cycle CPU write wins, then pending write-back.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_desc <= '0;
    end else if (lk_en) begin
      if (cpu_we && (cpu_idx == lk_idx))
        lk_desc <= wclean;
      else if (wb_en && (wb_idx == lk_idx))
        lk_desc <= lk_stored | wb_mask;
      else
        lk_desc <= lk_stored;
    end
  end

  p_clean_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[PAGE_BITS-1:FLAG_TOP+1] == '0);

  p_wb_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (filled[wb_idx] && wb_mask[BIT_USED]));

  p_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we |=> filled[$past(cpu_idx)]);

endmodule

// File: rtl/dpx_check.sv
module dpx_check
  import dpx_pkg::*;
#(
  parameter int IN_AW     = 24,
  parameter int PAGE_BITS = 13,
  parameter int LEN_W     = 16,
  parameter int BLK_BYTES = 16
) (
  input  logic [DESC_W-1:0] desc,
  input  logic [IN_AW-1:0]  faddr,
  input  logic              is_write,
  input  logic [LEN_W-1:0]  len,
  output verdict_t          v
);

  localparam logic [DESC_W-1:0] OFF_MASK = (DESC_W'(1) << PAGE_BITS) - DESC_W'(1);
  localparam logic [DESC_W-1:0] PA_MASK  = ~OFF_MASK;

  logic [DESC_W-1:0] offs;
  logic              len_odd;

  assign offs    = DESC_W'(faddr) & OFF_MASK;
  assign len_odd = (len % LEN_W'(BLK_BYTES)) != '0;

  always_comb begin
    v       = '0;
    v.cause = XC_NONE;
    if (desc[1:0] == 2'b00) begin
      v.fault = 1'b1;
      v.cause = XC_UNUSED;
    end else if (desc[1]) begin
      v.fault = 1'b1;
      v.cause = XC_BADTYPE;
    end else if (is_write && desc[BIT_WPROT]) begin
      v.fault = 1'b1;
      v.cause = XC_WPROT;
    end else if (desc[BIT_BLOCK] && len_odd) begin
      v.fault = 1'b1;
      v.cause = XC_BLOCK;
    end else begin
      v.paddr    = (desc & PA_MASK) | offs;
      v.nocache  = desc[BIT_NOCACHE];
      v.set_used = 1'b1;
      v.set_mod  = is_write;
    end
  end

  always_comb begin
    if (v.fault) a_fault_quiet_r8: assert (!v.set_used && !v.set_mod);
  end

endmodule

// File: rtl/dpx_resp_reg.sv
module dpx_resp_reg
  import dpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              drain,
  input  verdict_t          v,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [2:0]        rsp_cause,
  output logic [DESC_W-1:0] rsp_paddr,
  output logic              rsp_nocache
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_cause   <= '0;
      rsp_paddr   <= '0;
      rsp_nocache <= 1'b0;
    end else if (load) begin
      rsp_valid   <= 1'b1;
      rsp_fault   <= v.fault;
      rsp_cause   <= v.cause;
      rsp_paddr   <= v.paddr;
      rsp_nocache <= v.nocache;
    end else if (drain) begin
      rsp_valid   <= 1'b0;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !drain) |=> (rsp_valid && $stable(rsp_paddr) &&
                               $stable(rsp_cause) && $stable(rsp_fault)));

endmodule

// File: rtl/dpx_xlate_top.sv
module dpx_xlate_top
  import dpx_pkg::*;
#(
  parameter int IN_AW     = 24,
  parameter int PAGE_BITS = 13,
  parameter int LEN_W     = 16,
  parameter int BLK_BYTES = 16,
  localparam int IDX_W    = IN_AW - PAGE_BITS,
  localparam int DEVW     = $clog2(IN_AW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [IDX_W-1:0]  cpu_idx,
  input  logic [DESC_W-1:0] cpu_wdata,
  output logic [DESC_W-1:0] cpu_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IN_AW-1:0]  req_addr,
  input  logic [DEVW-1:0]   req_dev_bits,
  input  logic              req_write,
  input  logic [LEN_W-1:0]  req_len,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic [2:0]        rsp_cause,
  output logic [DESC_W-1:0] rsp_paddr,
  output logic              rsp_nocache
);

  // Force every address line the device does not drive to one.
  function automatic logic [IN_AW-1:0] align_top(input logic [IN_AW-1:0] a,
                                                 input logic [DEVW-1:0]  nb);
    logic [IN_AW-1:0] r;
    r = a;
    for (int i = 0; i < IN_AW; i++) if (i >= int'(nb)) r[i] = 1'b1;
    return r;
  endfunction

  logic [IN_AW-1:0]  folded;
  logic              acc;
  logic              s2_can;
  logic              s1_move;
  logic              s1_vld;
  logic [IN_AW-1:0]  s1_addr;
  logic              s1_wr;
  logic [LEN_W-1:0]  s1_len;
  logic [DESC_W-1:0] lk_desc;
  verdict_t          vd;
  logic              wb_en;
  logic [DESC_W-1:0] wb_mask;

  assign folded    = align_top(req_addr, req_dev_bits);
  assign s2_can    = !rsp_valid || rsp_ready;
  assign req_ready = !s1_vld || s2_can;
  assign acc       = req_valid && req_ready;
  assign s1_move   = s1_vld && s2_can;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_addr <= '0;
      s1_wr   <= 1'b0;
      s1_len  <= '0;
    end else begin
      if (acc) begin
        s1_vld  <= 1'b1;
        s1_addr <= folded;
        s1_wr   <= req_write;
        s1_len  <= req_len;
      end else if (s1_move) begin
        s1_vld  <= 1'b0;
      end
    end
  end

  dpx_desc_store #(
    .IDX_W     (IDX_W),
    .PAGE_BITS (PAGE_BITS)
  ) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_we    (cpu_we),
    .cpu_idx   (cpu_idx),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .lk_en     (acc),
    .lk_idx    (folded[IN_AW-1:PAGE_BITS]),
    .lk_desc   (lk_desc),
    .wb_en     (wb_en),
    .wb_idx    (s1_addr[IN_AW-1:PAGE_BITS]),
    .wb_mask   (wb_mask)
  );

  dpx_check #(
    .IN_AW     (IN_AW),
    .PAGE_BITS (PAGE_BITS),
    .LEN_W     (LEN_W),
    .BLK_BYTES (BLK_BYTES)
  ) check_i (
    .desc     (lk_desc),
    .faddr    (s1_addr),
    .is_write (s1_wr),
    .len      (s1_len),
    .v        (vd)
  );

  assign wb_en   = s1_move && vd.set_used;
  assign wb_mask = (DESC_W'(vd.set_used) << BIT_USED) |
                   (DESC_W'(vd.set_mod)  << BIT_MOD);

  dpx_resp_reg resp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (s1_move),
    .drain       (rsp_ready),
    .v           (vd),
    .rsp_valid   (rsp_valid),
    .rsp_fault   (rsp_fault),
    .rsp_cause   (rsp_cause),
    .rsp_paddr   (rsp_paddr),
    .rsp_nocache (rsp_nocache)
  );

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> s1_vld);

  p_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s1_move |=> rsp_valid);

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && rsp_valid && !rsp_ready) |-> !req_ready);

  p_fold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (int'(req_dev_bits) < IN_AW)) |-> folded[IN_AW-1]);

  p_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault == (rsp_cause != 3'd0)));

  p_fault_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && !rsp_nocache));

endmodule

// File: tb/dpx_xlate_top_tb_top.sv
module dpx_xlate_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [10:0] cpu_idx = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [4:0]  req_dev_bits = 5'd24;
  logic        req_write = 1'b0;
  logic [15:0] req_len = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_fault;
  logic [2:0]  rsp_cause;
  logic [31:0] rsp_paddr;
  logic        rsp_nocache;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  dpx_xlate_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_we(cpu_we), .cpu_idx(cpu_idx), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_dev_bits(req_dev_bits), .req_write(req_write), .req_len(req_len),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr), .rsp_nocache(rsp_nocache)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bench model of the top-aligned fold.
  function automatic logic [23:0] m_fold(input logic [23:0] a, input logic [4:0] nb);
    logic [23:0] r;
    r = a;
    for (int i = 23; i >= 0; i--) r[i] = (i >= nb) ? 1'b1 : a[i];
    return r;
  endfunction

  // Bench model of the verdict: {cause, nocache, paddr}.
  function automatic logic [35:0] m_expect(input logic [31:0] d, input logic [23:0] fa,
                                           input logic wr, input logic [15:0] len);
    if (d[1:0] == 2'b00)               return {3'd1, 1'b0, 32'h0};
    if (d[1])                          return {3'd2, 1'b0, 32'h0};
    if (wr && d[2])                    return {3'd3, 1'b0, 32'h0};
    if (d[5] && (len[3:0] != 4'h0))    return {3'd4, 1'b0, 32'h0};
    return {3'd0, d[6], d[31:13], fa[12:0]};
  endfunction

  task automatic cpu_write(input logic [10:0] idx, input logic [31:0] val);
    @(negedge clk);
    cpu_we = 1'b1; cpu_idx = idx; cpu_wdata = val;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic cpu_read(input logic [10:0] idx, output logic [31:0] val);
    @(negedge clk);
    cpu_idx = idx;
    @(negedge clk);
    val = cpu_rdata;
  endtask

  task automatic do_req(input logic [23:0] a, input logic [4:0] nb, input logic wr,
                        input logic [15:0] len, output logic [35:0] got);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_dev_bits = nb; req_write = wr; req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!rsp_valid, "R9 no response one clock after accept", 32'(rsp_valid), 32'h0);
    @(negedge clk);
    chk(rsp_valid, "R9 response two clocks after accept", 32'(rsp_valid), 32'h1);
    got = {rsp_cause, rsp_nocache, rsp_paddr};
    chk(rsp_fault == (rsp_cause != 3'd0), "R5 fault flag matches cause",
        32'(rsp_fault), 32'(rsp_cause != 3'd0));
  endtask

  localparam int NV = 13;
  // {descriptor, address, device bits, write, length}
  localparam logic [77:0] VECS [NV] = '{
    {32'hABCDE041, 24'h004123, 5'd24, 1'b0, 16'd64},   // R3 ok, no-cache
    {32'h12340001, 24'h002345, 5'd16, 1'b1, 16'd32},   // R4 16-bit device
    {32'h55550000, 24'h006000, 5'd24, 1'b0, 16'd16},   // R5 unused entry
    {32'h55552002, 24'h008010, 5'd24, 1'b0, 16'd16},   // R5 type 10
    {32'h55552007, 24'h00A010, 5'd24, 1'b1, 16'd16},   // R5 type 11 beats wp
    {32'h77770005, 24'h00C100, 5'd24, 1'b1, 16'd16},   // R6 write to wp page
    {32'h77770005, 24'h00C100, 5'd24, 1'b0, 16'd16},   // R6 read of wp page
    {32'h88880021, 24'h00E004, 5'd24, 1'b0, 16'd24},   // R7 odd length
    {32'h88880021, 24'h00E004, 5'd24, 1'b0, 16'd48},   // R7 whole blocks
    {32'h99990025, 24'h010000, 5'd24, 1'b1, 16'd5},    // R7 wp wins over block
    {32'hCAFEE001, 24'hFFFFFF, 5'd24, 1'b0, 16'd1},    // R3 top entry
    {32'h0BAD2041, 24'h000000, 5'd0,  1'b1, 16'd0},    // R4 zero-width device
    {32'h31410001, 24'h001ABC, 5'd13, 1'b0, 16'd8}     // R4 fold above offset
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    logic [35:0] got;
    logic [35:0] exp;
    logic [23:0] fa;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty table after reset.
    cpu_read(11'd7, rd);
    chk(rd == 32'h0, "R1 descriptor reads zero after reset", rd, 32'h0);
    chk(!rsp_valid && req_ready, "R1 idle after reset", 32'({rsp_valid, req_ready}), 32'h1);
    do_req(24'h00E000, 5'd24, 1'b0, 16'd16, got);
    chk(got[35:33] == 3'd1, "R1 request to empty table faults cause 1",
        32'(got[35:33]), 32'd1);

    // Vector table.
    for (int k = 0; k < NV; k++) begin
      logic [31:0] d;
      logic [23:0] a;
      logic [4:0]  nb;
      logic        w;
      logic [15:0] ln;
      {d, a, nb, w, ln} = VECS[k];
      fa  = m_fold(a, nb);
      cpu_write(fa[23:13], d);
      do_req(a, nb, w, ln, got);
      exp = m_expect(d, fa, w, ln);
      chk(got == exp, $sformatf("R3/R4/R5/R6/R7/R11 vector %0d", k), got[31:0], exp[31:0]);
      chk(got[35:32] == exp[35:32], $sformatf("R5 cause/nocache vector %0d", k),
          32'(got[35:32]), 32'(exp[35:32]));
    end

    // R2: reserved bits dropped.
    cpu_write(11'd300, 32'hFFFFFFFF);
    cpu_read(11'd300, rd);
    chk(rd == 32'hFFFFE07F, "R2 reserved bits read zero", rd, 32'hFFFFE07F);

    // R8: used / modified bookkeeping.
    cpu_write(11'd100, 32'h30000001);
    do_req(24'h0C8010, 5'd24, 1'b0, 16'd4, got);
    cpu_read(11'd100, rd);
    chk(rd == 32'h30000009, "R8 read sets used only", rd, 32'h30000009);
    do_req(24'h0C8010, 5'd24, 1'b1, 16'd4, got);
    cpu_read(11'd100, rd);
    chk(rd == 32'h30000019, "R8 write sets modified", rd, 32'h30000019);
    cpu_write(11'd100, 32'h30000005);
    do_req(24'h0C8010, 5'd24, 1'b1, 16'd4, got);
    chk(got[35:33] == 3'd3, "R8 wp fault cause", 32'(got[35:33]), 32'd3);
    cpu_read(11'd100, rd);
    chk(rd == 32'h30000005, "R8 fault leaves entry unchanged", rd, 32'h30000005);

    // R10: same-cycle CPU write seen by the lookup.
    @(negedge clk);
    cpu_we = 1'b1; cpu_idx = 11'd200; cpu_wdata = 32'h40000001;
    req_valid = 1'b1; req_addr = 24'h190010; req_dev_bits = 5'd24;
    req_write = 1'b0; req_len = 16'd16;
    @(negedge clk);
    cpu_we = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid && !rsp_fault && rsp_paddr == 32'h40000010,
        "R10 request sees same-cycle write", rsp_paddr, 32'h40000010);

    // R9: back-pressure fills both stages.
    cpu_write(11'd400, 32'h50000001);
    cpu_write(11'd401, 32'h60000001);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 24'h320008; req_write = 1'b0;
    @(negedge clk);
    chk(req_ready, "R9 second stage still free", 32'(req_ready), 32'h1);
    req_addr = 24'h322008;
    @(negedge clk);
    chk(rsp_valid && rsp_paddr == 32'h50000008, "R9 first response", rsp_paddr, 32'h50000008);
    chk(!req_ready, "R9 ready low when full", 32'(req_ready), 32'h0);
    req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid && rsp_paddr == 32'h50000008, "R9 response held", rsp_paddr, 32'h50000008);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid && rsp_paddr == 32'h60000008, "R9 second response", rsp_paddr, 32'h60000008);
    @(negedge clk);
    chk(!rsp_valid, "R9 drained", 32'(rsp_valid), 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule